// File: doc/BRIEF.md
# Fractional M/N Clock Divider

This block derives a low-rate clock, typically an audio sample or bit clock, from one of four source rates. Each source arrives as a single-cycle tick strobe in the block's own clock domain. The output frequency is the selected tick rate multiplied by M and divided by N. A phase accumulator produces the output. It gains 2·M on every selected tick and gives back N whenever it reaches N, and the output flips on every give-back. Each half period therefore averages N/(2·M) ticks, and the duty cycle stays close to one half.

One 32-bit control word holds the whole setting, and software writes it through a plain write port. The full word can be read back at any time. The running generator takes a new setting only at a clean point: while it is stopped, or on a falling output edge. A setting that breaks the range or ratio rules holds the output low. The block never produces a wrong frequency from a bad setting. Turning the enable off lets a high phase that is already in progress finish before the output parks low.

Top module: `mn_frac_clkdiv`

## Requirements
- R1: After reset, `clk_o` is 0 and `rd_data` is all zeros.
- R2: `rd_data` returns the complete last written control word, all 32 bits, starting in the cycle after the write.
- R3: The control word layout is: N in bits [19:0], M in bits [28:20], enable in bit 29, source select in bits [31:30]. Select value k picks `src_tick[k]`.
- R4: With a valid setting running, every N selected ticks produce exactly M output periods. A setting of M=3, N=10 on an every-cycle source gives 30 rising edges in any 100-cycle window.
- R5: An integer divide is written as M=1. With M=1 and N=6 on an every-cycle source, the output has a period of exactly 6 cycles.
- R6: Only ticks of the selected source advance the output. Ticks on the other sources have no effect on `clk_o`.
- R7: A setting is valid only when M≥1, N≥2 and N≥2·M. An invalid setting keeps `clk_o` low. The boundary case N=2·M is valid and toggles the output on every tick.
- R8: Clearing the enable parks `clk_o` low. If the output is high at that moment, the current high phase runs to its normal end, so no shortened pulse is produced.
- R9: A new M, N or select value written while the output runs takes effect at the next falling output edge, with the accumulator cleared to zero. Until that edge the old ratio continues.
- R10: When the block is stopped, a valid enabled setting starts generation one cycle after it lands in the register. The output starts low with a zero accumulator.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock; all tick strobes are synchronous to it |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_tick | input | 4 | One tick strobe per source rate |
| wr_en | input | 1 | Write strobe for the control word |
| wr_data | input | 32 | Control word to write |
| rd_data | output | 32 | Current control word |
| clk_o | output | 1 | Divided, gated output clock |

## Verification
The hardest case to reach is a reconfiguration, or a disable, that lands during a high phase of the output. In that case the block must finish the old half period before it switches. The stimulus first watches `clk_o` until the output is seen high, and only then issues the write. A behavioural reference model checks every following cycle. Window counts of rising edges then confirm that the new ratio has settled. The counts also confirm that an invalid or disabled setting produces no edge at all.

// File: rtl/mn_pkg.sv
package mn_pkg;

  localparam int unsigned MN_SRC_DEF = 4;
  localparam int unsigned MN_M_W_DEF = 9;
  localparam int unsigned MN_N_W_DEF = 20;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } run_state_e;

  // Legal when m is non-zero, n is at least 2 and n is at least twice m.
  function automatic logic ratio_ok(input logic [31:0] m, input logic [31:0] n);
    return (m != 32'd0) && (n >= 32'd2) && (n >= {m[30:0], 1'b0});
  endfunction

endpackage

// File: rtl/mn_ctrl_reg.sv
module mn_ctrl_reg #(
  parameter int unsigned REG_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  output logic [REG_W-1:0] ctrl_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     ctrl_q <= '0;
    else if (wr_en) ctrl_q <= wr_data;
  end

  // R2: a write is visible on the next cycle
  p_readback_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(wr_en)) |-> (ctrl_q == $past(wr_data)));

endmodule

// File: rtl/mn_cfg_decode.sv
module mn_cfg_decode #(
  parameter int unsigned SEL_W = 2,
  parameter int unsigned M_W   = 9,
  parameter int unsigned N_W   = 20,
  localparam int unsigned REG_W = SEL_W + 1 + M_W + N_W
) (
  input  logic [REG_W-1:0] word,
  output logic [SEL_W-1:0] sel,
  output logic             en,
  output logic [M_W-1:0]   m,
  output logic [N_W-1:0]   n,
  output logic             ok
);

  assign n   = word[N_W-1:0];
  assign m   = word[N_W +: M_W];
  assign en  = word[N_W + M_W];
  assign sel = word[REG_W-1 -: SEL_W];
  assign ok  = mn_pkg::ratio_ok(32'(m), 32'(n));

endmodule

// File: rtl/mn_src_pick.sv
module mn_src_pick #(
  parameter int unsigned NUM_SRC = 4,
  localparam int unsigned SEL_W = $clog2(NUM_SRC)
) (
  input  logic [NUM_SRC-1:0] src_tick,
  input  logic [SEL_W-1:0]   sel,
  output logic               tick
);

  logic [NUM_SRC-1:0] hit;

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_hit
    assign hit[i] = src_tick[i] && (sel == SEL_W'(i));
  end

  assign tick = |hit;

endmodule

// File: rtl/mn_phase_acc.sv
module mn_phase_acc #(
  parameter int unsigned M_W = 9,
  parameter int unsigned N_W = 20
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           clr,
  input  logic           adv,
  input  logic [M_W-1:0] m,
  input  logic [N_W-1:0] n,
  output logic [N_W-1:0] acc_q,
  output logic           out_q,
  output logic           fall_evt
);

  logic [N_W:0] sum;
  logic [N_W:0] diff;
  logic         wrap;

  assign sum      = {1'b0, acc_q} + {{(N_W - M_W){1'b0}}, m, 1'b0};
  assign diff     = sum - {1'b0, n};
  assign wrap     = (sum >= {1'b0, n});
  assign fall_evt = adv && out_q && wrap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
      out_q <= 1'b0;
    end else if (clr) begin
      acc_q <= '0;
      out_q <= 1'b0;
    end else if (adv) begin
      if (wrap) begin
        acc_q <= diff[N_W-1:0];
        out_q <= ~out_q;
      end else begin
        acc_q <= sum[N_W-1:0];
      end
    end
  end

  // R4: without clear or advance the phase does not move
  p_hold_phase_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !adv) |=> ($stable(acc_q) && $stable(out_q)));

endmodule

// File: rtl/mn_frac_clkdiv.sv
module mn_frac_clkdiv #(
  parameter int unsigned NUM_SRC = mn_pkg::MN_SRC_DEF,
  parameter int unsigned M_W     = mn_pkg::MN_M_W_DEF,
  parameter int unsigned N_W     = mn_pkg::MN_N_W_DEF,
  localparam int unsigned SEL_W  = $clog2(NUM_SRC),
  localparam int unsigned REG_W  = SEL_W + 1 + M_W + N_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_tick,
  input  logic               wr_en,
  input  logic [REG_W-1:0]   wr_data,
  output logic [REG_W-1:0]   rd_data,
  output logic               clk_o
);

  import mn_pkg::*;

  logic [REG_W-1:0] ctrl_q;
  logic [SEL_W-1:0] cfg_sel;
  logic             cfg_en;
  logic [M_W-1:0]   cfg_m;
  logic [N_W-1:0]   cfg_n;
  logic             cfg_ok;

  run_state_e       state_q;
  logic [SEL_W-1:0] act_sel;
  logic [M_W-1:0]   act_m;
  logic [N_W-1:0]   act_n;

  logic             tick;
  logic             adv;
  logic             clr;
  logic             pending;
  logic             stop_now;
  logic             fall_evt;
  logic [N_W-1:0]   acc_q;
  logic             out_q;

  mn_ctrl_reg #(.REG_W(REG_W)) u_reg (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .ctrl_q  (ctrl_q)
  );

  mn_cfg_decode #(.SEL_W(SEL_W), .M_W(M_W), .N_W(N_W)) u_dec (
    .word (ctrl_q),
    .sel  (cfg_sel),
    .en   (cfg_en),
    .m    (cfg_m),
    .n    (cfg_n),
    .ok   (cfg_ok)
  );

  mn_src_pick #(.NUM_SRC(NUM_SRC)) u_pick (
    .src_tick (src_tick),
    .sel      (act_sel),
    .tick     (tick)
  );

  assign pending  = !cfg_en || (cfg_sel != act_sel) || (cfg_m != act_m) || (cfg_n != act_n);
  assign stop_now = (state_q == ST_RUN) && !cfg_en && !out_q;
  assign adv      = (state_q == ST_RUN) && tick;
  assign clr      = (state_q == ST_IDLE) || stop_now || (fall_evt && pending);

  mn_phase_acc #(.M_W(M_W), .N_W(N_W)) u_acc (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (clr),
    .adv      (adv),
    .m        (act_m),
    .n        (act_n),
    .acc_q    (acc_q),
    .out_q    (out_q),
    .fall_evt (fall_evt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      act_sel <= '0;
      act_m   <= '0;
      act_n   <= '0;
    end else if ((state_q == ST_IDLE) || (fall_evt && pending)) begin
      act_sel <= cfg_sel;
      act_m   <= cfg_m;
      act_n   <= cfg_n;
      state_q <= (cfg_en && cfg_ok) ? ST_RUN : ST_IDLE;
    end else if (stop_now) begin
      state_q <= ST_IDLE;
    end
  end

  assign rd_data = ctrl_q;
  assign clk_o   = out_q;

  // R8: stopped generator drives low
  p_idle_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE) |-> !clk_o);

  // R7: only legal ratios ever run
  p_run_legal_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_RUN) |-> ratio_ok(32'(act_m), 32'(act_n)));

  // R4: accumulator stays below N while running
  p_acc_below_n_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_RUN) |-> (acc_q < act_n));

  // R6: no selected tick, no output change
  p_no_tick_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == ST_RUN) && !tick) |=> $stable(clk_o));

  // R9: active ratio is frozen through a high phase
  p_cfg_frozen_high_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == ST_RUN) && clk_o) |=>
      (!clk_o || ($stable(act_m) && $stable(act_n) && $stable(act_sel))));

endmodule

// File: tb/sim_mn_frac_clkdiv.sv
`timescale 1ns/1ps
module sim_mn_frac_clkdiv;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  src_tick = 4'b0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = 32'h0;
  logic [31:0] rd_data;
  logic        clk_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;
  string stage = "R1";
  int cyc = 0;

  always #2 clk = ~clk;

  mn_frac_clkdiv u0 (
    .clk      (clk),
    .rst_n    (rst_n),
    .src_tick (src_tick),
    .wr_en    (wr_en),
    .wr_data  (wr_data),
    .rd_data  (rd_data),
    .clk_o    (clk_o)
  );

  // Source patterns: every cycle, every 2nd, every 3rd, every 5th
  always @(negedge clk) begin
    cyc <= cyc + 1;
    src_tick <= {(cyc % 5) == 0, (cyc % 3) == 0, (cyc % 2) == 0, 1'b1};
  end

  function automatic logic [31:0] mk(int sel, int en, int m, int n);
    return {sel[1:0], en[0], m[8:0], n[19:0]};
  endfunction

  function automatic bit legal(longint m, longint n);
    return (m >= 1) && (n >= 2) && (n >= 2 * m);
  endfunction

  // Behavioural reference
  longint mr_acc = 0, mr_m = 0, mr_n = 0;
  int     mr_sel = 0;
  bit     mr_run = 0, mr_out = 0;
  logic [31:0] mr_ctrl = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      mr_acc = 0; mr_m = 0; mr_n = 0; mr_sel = 0;
      mr_run = 0; mr_out = 0; mr_ctrl = 0;
    end else begin
      longint cm, cn, s;
      int cs;
      bit cen, chg;
      cn  = mr_ctrl[19:0];
      cm  = mr_ctrl[28:20];
      cen = mr_ctrl[29];
      cs  = mr_ctrl[31:30];
      if (!mr_run) begin
        mr_m = cm; mr_n = cn; mr_sel = cs;
        mr_run = cen && legal(cm, cn);
        mr_acc = 0; mr_out = 0;
      end else if (!cen && !mr_out) begin
        mr_run = 0; mr_acc = 0; mr_out = 0;
      end else if (src_tick[mr_sel]) begin
        s = mr_acc + 2 * mr_m;
        if (s >= mr_n) begin
          s = s - mr_n;
          if (mr_out) begin
            chg = !cen || cm != mr_m || cn != mr_n || cs != mr_sel;
            if (chg) begin
              mr_m = cm; mr_n = cn; mr_sel = cs;
              mr_run = cen && legal(cm, cn);
              mr_acc = 0;
            end else begin
              mr_acc = s;
            end
            mr_out = 0;
          end else begin
            mr_acc = s;
            mr_out = 1;
          end
        end else begin
          mr_acc = s;
        end
      end
      if (wr_en) mr_ctrl = wr_data;
      #1;
      checks++;
      if (clk_o !== mr_out || rd_data !== mr_ctrl) begin
        fails++;
        $display("FAIL %s (R2/R3 word, output): clk_o=%0b exp %0b rd_data=%h exp %h",
                 stage, clk_o, mr_out, rd_data, mr_ctrl);
      end
    end
  end

  task automatic wr(input logic [31:0] w);
    @(negedge clk);
    wr_en = 1'b1;
    wr_data = w;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic rises(input int n, input int exp, input string tag);
    int r = 0;
    logic prev;
    @(posedge clk); #2;
    prev = clk_o;
    repeat (n) begin
      @(posedge clk); #2;
      if (!prev && clk_o) r++;
      prev = clk_o;
    end
    checks++;
    if (r != exp) begin
      fails++;
      $display("FAIL %s: rising edges=%0d exp %0d", tag, r, exp);
    end
  endtask

  task automatic wait_high();
    int guard = 0;
    do begin
      @(posedge clk); #2;
      guard++;
    end while (!clk_o && guard < 200);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    checks++;
    if (clk_o !== 1'b0 || rd_data !== 32'h0) begin
      fails++;
      $display("FAIL R1: clk_o=%0b exp 0 rd_data=%h exp 0", clk_o, rd_data);
    end
    rst_n = 1'b1;
    idle(3);

    stage = "R5"; // integer divide by 6
    wr(mk(0, 1, 1, 6));
    idle(20);
    rises(60, 10, "R5 M=1 N=6");

    stage = "R9"; // change ratio mid-run, taken at falling edge
    wait_high();
    wr(mk(0, 1, 1, 10));
    idle(30);
    rises(100, 10, "R9 M=1 N=10");

    stage = "R4"; // fractional 3/10
    wr(mk(0, 1, 3, 10));
    idle(40);
    rises(100, 30, "R4 M=3 N=10");

    stage = "R6"; // source 2: every 3rd cycle
    wr(mk(2, 1, 1, 4));
    idle(60);
    rises(120, 10, "R6 sel2 M=1 N=4");
    wr(mk(3, 1, 1, 2)); // source 3: every 5th cycle
    idle(60);
    rises(100, 10, "R6 sel3 M=1 N=2");

    stage = "R8"; // disable during a high phase
    wait_high();
    wr(mk(3, 0, 1, 2));
    idle(30);
    rises(50, 0, "R8 disabled");
    checks++;
    if (rd_data[29] !== 1'b0 || clk_o !== 1'b0) begin
      fails++;
      $display("FAIL R8: en=%0b clk_o=%0b exp 0 0", rd_data[29], clk_o);
    end

    stage = "R7"; // boundary N=2M, then illegal settings
    wr(mk(0, 1, 511, 1022));
    idle(10);
    rises(100, 50, "R7 M=511 N=1022");
    wr(mk(0, 1, 0, 8));
    idle(10);
    rises(60, 0, "R7 M=0");
    wr(mk(0, 1, 3, 5));
    idle(10);
    rises(60, 0, "R7 N<2M");
    wr(mk(0, 1, 1, 1));
    idle(10);
    rises(60, 0, "R7 N=1");

    stage = "R10"; // restart from stopped
    wr(mk(1, 1, 1, 2));
    idle(20);
    rises(80, 20, "R10 sel1 M=1 N=2");

    stage = "R3";
    wr(32'hA5A5_5A5A);
    idle(4);
    checks++;
    if (rd_data !== 32'hA5A5_5A5A) begin
      fails++;
      $display("FAIL R3: rd_data=%h exp a5a55a5a", rd_data);
    end

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(4 * 150000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: run did not finish, exp completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule